// File: doc/BRIEF.md
# Timer Control and Status Register Block

This block is the software-visible register file of a time-of-day timer subsystem. A host reaches it over a simple 32-bit bus that uses byte addresses, a write enable, write data and a combinational read-data return. It holds the timer configuration, the interrupt enables and the sticky interrupt status. It also holds a software-supplied time value and a software-supplied offset value. Configuration and software values are presented as steady outputs to the timer datapath. Snapshot and load requests leave the block as single-cycle pulses.

Two once-per-second event inputs feed the interrupt logic. One event comes from the master timer's seconds rollover and the other from an external pulse-per-second pin. Each event sets its own sticky status bit. The single level interrupt output is raised while any status bit is set together with its enable. The live system-timer seconds and nanoseconds enter as inputs and can be read back through read-only locations.

The block mixes several access kinds in one map. Some registers are read-write. Some bits are write-one-to-trigger and always read back as 0. The status register is write-one-to-clear. The offset registers are write-only and read back as 0. The readback locations are read-only. Every address not listed below, including any address not aligned to a 32-bit word, reads as 0 and ignores writes.

Top module: `timer_csr`

## Requirements
- R1: After reset, every readable register reads 0 except the read-only time locations. All configuration, software-value, pulse and interrupt outputs are 0.
- R2: The configuration word at byte address 0x000 is read-write. Bit 0 drives sysTimerEn, bit 1 drives extBusEn, bits 3:2 drive overwriteMode, bit 4 drives autoRefreshEn and bit 5 drives ppsSnapEn. Bits 16 to 16+PORTS-1 drive portEn. All other bits read 0.
- R3: Writing 1 to bit 0 of address 0x004 raises snapPulse for one cycle, the cycle after the write. Writing 0 raises nothing. The address always reads 0.
- R4: At address 0x01C, writing 1 to bit 0 pulses loadTimePulse and writing 1 to bit 1 pulses loadOffsetPulse. Each pulse lasts one cycle and comes the cycle after the write. Zero bits raise nothing, and the address always reads 0.
- R5: The interrupt-enable word at 0x008 is read-write. Bit 0 enables the master-seconds source and bit 16 enables the external-pin source. All other bits read 0.
- R6: The status word at 0x00C uses bit 0 for masterPpsEvt and bit 16 for extPpsEvt. A one-cycle event sets its bit whether or not that source is enabled, and the bit stays set.
- R7: Writing a 1 to a status bit clears it. Writing a 0 leaves it unchanged. Writes to the status word change nothing else.
- R8: When a clear write and an event reach the same status bit in the same cycle, the bit ends up 1.
- R9: irq is 1 exactly when some status bit and its matching enable bit are both 1.
- R10: Software time is read-write. Address 0x010 holds seconds bits 31:0. Address 0x014 bits 15:0 hold seconds bits 47:32. Address 0x018 bits 29:0 hold nanoseconds. These drive swSec and swNs, and unused bits read 0.
- R11: Software offset is write-only and uses the same field layout at 0x028, 0x02C and 0x030. It drives swOffSec and swOffNs, and these three addresses always read 0.
- R12: Addresses 0x100, 0x104 and 0x108 read sysSecIn bits 31:0, sysSecIn bits 47:32 (in bits 15:0), and sysNsIn (in bits 29:0). Writes to them have no effect.
- R13: Unmapped or unaligned addresses read 0. Writes to them change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busAddr | input | ADDR_W | Byte address |
| busWrEn | input | 1 | Write enable |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr, combinational |
| masterPpsEvt | input | 1 | One-cycle master seconds event |
| extPpsEvt | input | 1 | One-cycle external pulse-per-second event |
| sysSecIn | input | SEC_W | Live system timer seconds |
| sysNsIn | input | NS_W | Live system timer nanoseconds |
| sysTimerEn | output | 1 | System timer enable |
| extBusEn | output | 1 | External time bus enable |
| overwriteMode | output | 2 | Overwrite mode select |
| autoRefreshEn | output | 1 | Port timer auto-refresh enable |
| ppsSnapEn | output | 1 | Snapshot on external pulse enable |
| portEn | output | PORTS | Per-port timer enables |
| snapPulse | output | 1 | Snapshot-all request pulse |
| loadTimePulse | output | 1 | Load software time pulse |
| loadOffsetPulse | output | 1 | Load software offset pulse |
| swSec | output | SEC_W | Software seconds value |
| swNs | output | NS_W | Software nanoseconds value |
| swOffSec | output | SEC_W | Software seconds offset |
| swOffNs | output | NS_W | Software nanoseconds offset |
| irq | output | 1 | Level interrupt |

## Verification
The assertions check several rules on every cycle. Each trigger pulse must trace back to a qualifying write one cycle earlier. An event must always leave its status bit set, even when a clear arrives in the same cycle. A clear without a competing event must drop the bit. irq may only rise after an event or an enable write. At most one write strobe may be active at a time, and the trigger and write-only addresses must always read 0.
Other behaviour only the bench's sweeps can show. These are the exact bit masks of each register and the field placement of the multi-word values. They also include the full truth table of the interrupt output over every enable and status combination, and the fact that writes of all ones to every unmapped or read-only word change nothing.

// File: rtl/timer_csr_pkg.sv
package timer_csr_pkg;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_CFG, SEL_SNAP, SEL_IEN, SEL_ISTS, SEL_SECLO, SEL_SECHI,
    SEL_NS, SEL_LOAD, SEL_OFFLO, SEL_OFFHI, SEL_OFFNS, SEL_SYSLO, SEL_SYSHI,
    SEL_SYSNS
  } regSel_e;

  typedef struct packed {
    logic cfg;
    logic snap;
    logic ien;
    logic ists;
    logic secLo;
    logic secHi;
    logic ns;
    logic load;
    logic offLo;
    logic offHi;
    logic offNs;
  } wrStrobe_t;

  localparam logic [31:0] A_CFG   = 32'h000;
  localparam logic [31:0] A_SNAP  = 32'h004;
  localparam logic [31:0] A_IEN   = 32'h008;
  localparam logic [31:0] A_ISTS  = 32'h00C;
  localparam logic [31:0] A_SECLO = 32'h010;
  localparam logic [31:0] A_SECHI = 32'h014;
  localparam logic [31:0] A_NS    = 32'h018;
  localparam logic [31:0] A_LOAD  = 32'h01C;
  localparam logic [31:0] A_OFFLO = 32'h028;
  localparam logic [31:0] A_OFFHI = 32'h02C;
  localparam logic [31:0] A_OFFNS = 32'h030;
  localparam logic [31:0] A_SYSLO = 32'h100;
  localparam logic [31:0] A_SYSHI = 32'h104;
  localparam logic [31:0] A_SYSNS = 32'h108;

  localparam int IRQ_SRCS = 2;
  // source 0: master seconds event, source 1: external pin event
  localparam int IRQ_BIT_POS [IRQ_SRCS] = '{0, 16};
  localparam int PORT_EN_LSB = 16;

endpackage

// File: rtl/timer_csr_ctrl.sv
module timer_csr_ctrl
  import timer_csr_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  output regSel_e           sel,
  output wrStrobe_t         stb
);

  logic [31:0] addrExt;
  assign addrExt = 32'(addr);

  always_comb begin
    case (addrExt)
      A_CFG:   sel = SEL_CFG;
      A_SNAP:  sel = SEL_SNAP;
      A_IEN:   sel = SEL_IEN;
      A_ISTS:  sel = SEL_ISTS;
      A_SECLO: sel = SEL_SECLO;
      A_SECHI: sel = SEL_SECHI;
      A_NS:    sel = SEL_NS;
      A_LOAD:  sel = SEL_LOAD;
      A_OFFLO: sel = SEL_OFFLO;
      A_OFFHI: sel = SEL_OFFHI;
      A_OFFNS: sel = SEL_OFFNS;
      A_SYSLO: sel = SEL_SYSLO;
      A_SYSHI: sel = SEL_SYSHI;
      A_SYSNS: sel = SEL_SYSNS;
      default: sel = SEL_NONE;
    endcase
  end

  always_comb begin
    stb       = '0;
    stb.cfg   = wrEn && (sel == SEL_CFG);
    stb.snap  = wrEn && (sel == SEL_SNAP);
    stb.ien   = wrEn && (sel == SEL_IEN);
    stb.ists  = wrEn && (sel == SEL_ISTS);
    stb.secLo = wrEn && (sel == SEL_SECLO);
    stb.secHi = wrEn && (sel == SEL_SECHI);
    stb.ns    = wrEn && (sel == SEL_NS);
    stb.load  = wrEn && (sel == SEL_LOAD);
    stb.offLo = wrEn && (sel == SEL_OFFLO);
    stb.offHi = wrEn && (sel == SEL_OFFHI);
    stb.offNs = wrEn && (sel == SEL_OFFNS);
  end

  // R13: one register written at most, and none without a write
  p_strobe_onehot_r13: assert property (@(posedge clk) disable iff (rst)
    $onehot0(stb));
  p_no_write_r13: assert property (@(posedge clk) disable iff (rst)
    !wrEn |-> (stb == '0));

endmodule

// File: rtl/timer_csr_dp.sv
module timer_csr_dp
  import timer_csr_pkg::*;
#(
  parameter int SEC_W = 48,
  parameter int NS_W  = 30,
  parameter int PORTS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  regSel_e          sel,
  input  wrStrobe_t        stb,
  input  logic [31:0]      wrData,
  input  logic             masterPpsEvt,
  input  logic             extPpsEvt,
  input  logic [SEC_W-1:0] sysSecIn,
  input  logic [NS_W-1:0]  sysNsIn,
  output logic [31:0]      rdData,
  output logic             sysTimerEn,
  output logic             extBusEn,
  output logic [1:0]       overwriteMode,
  output logic             autoRefreshEn,
  output logic             ppsSnapEn,
  output logic [PORTS-1:0] portEn,
  output logic             snapPulse,
  output logic             loadTimePulse,
  output logic             loadOffsetPulse,
  output logic [SEC_W-1:0] swSec,
  output logic [NS_W-1:0]  swNs,
  output logic [SEC_W-1:0] swOffSec,
  output logic [NS_W-1:0]  swOffNs,
  output logic             irq
);

  localparam int SEC_HI_W = SEC_W - 32;

  logic [5:0]          cfgLow;
  logic [PORTS-1:0]    portEnR;
  logic [SEC_W-1:0]    swSecR, swOffSecR;
  logic [NS_W-1:0]     swNsR, swOffNsR;
  logic [IRQ_SRCS-1:0] srcEvt;
  logic [IRQ_SRCS-1:0] stsR;
  logic [IRQ_SRCS-1:0] ienR;
  logic                unusedWrData;

  assign unusedWrData = ^wrData;
  assign srcEvt = {extPpsEvt, masterPpsEvt};

  always_ff @(posedge clk) begin
    if (rst) begin
      cfgLow          <= '0;
      portEnR         <= '0;
      swSecR          <= '0;
      swNsR           <= '0;
      swOffSecR       <= '0;
      swOffNsR        <= '0;
      snapPulse       <= 1'b0;
      loadTimePulse   <= 1'b0;
      loadOffsetPulse <= 1'b0;
    end else begin
      if (stb.cfg) begin
        cfgLow  <= wrData[5:0];
        portEnR <= wrData[PORT_EN_LSB +: PORTS];
      end
      if (stb.secLo) swSecR[31:0]        <= wrData;
      if (stb.secHi) swSecR[SEC_W-1:32]  <= wrData[SEC_HI_W-1:0];
      if (stb.ns)    swNsR               <= wrData[NS_W-1:0];
      if (stb.offLo) swOffSecR[31:0]     <= wrData;
      if (stb.offHi) swOffSecR[SEC_W-1:32] <= wrData[SEC_HI_W-1:0];
      if (stb.offNs) swOffNsR            <= wrData[NS_W-1:0];
      snapPulse       <= stb.snap && wrData[0];
      loadTimePulse   <= stb.load && wrData[0];
      loadOffsetPulse <= stb.load && wrData[1];
    end
  end

  for (genvar s = 0; s < IRQ_SRCS; s++) begin : g_irq
    always_ff @(posedge clk) begin
      if (rst) begin
        stsR[s] <= 1'b0;
        ienR[s] <= 1'b0;
      end else begin
        if (stb.ien) ienR[s] <= wrData[IRQ_BIT_POS[s]];
        // event has priority over a clear in the same cycle
        stsR[s] <= (stsR[s] && !(stb.ists && wrData[IRQ_BIT_POS[s]])) || srcEvt[s];
      end
    end

    // R6, R8: an event always leaves its status bit set
    p_evt_sets_r8: assert property (@(posedge clk) disable iff (rst)
      srcEvt[s] |=> stsR[s]);
    // R7: a clear with no competing event drops the bit
    p_clear_r7: assert property (@(posedge clk) disable iff (rst)
      (stb.ists && wrData[IRQ_BIT_POS[s]] && !srcEvt[s]) |=> !stsR[s]);
    // R6: a status bit never drops without a clear write
    p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
      (stsR[s] && !stb.ists) |=> stsR[s]);
  end

  always_comb begin
    irq = 1'b0;
    for (int s = 0; s < IRQ_SRCS; s++) irq = irq | (stsR[s] & ienR[s]);
  end

  always_comb begin
    rdData = '0;
    case (sel)
      SEL_CFG: begin
        rdData[5:0]                  = cfgLow;
        rdData[PORT_EN_LSB +: PORTS] = portEnR;
      end
      SEL_IEN:  for (int s = 0; s < IRQ_SRCS; s++) rdData[IRQ_BIT_POS[s]] = ienR[s];
      SEL_ISTS: for (int s = 0; s < IRQ_SRCS; s++) rdData[IRQ_BIT_POS[s]] = stsR[s];
      SEL_SECLO: rdData = swSecR[31:0];
      SEL_SECHI: rdData[SEC_HI_W-1:0] = swSecR[SEC_W-1:32];
      SEL_NS:    rdData[NS_W-1:0] = swNsR;
      SEL_SYSLO: rdData = sysSecIn[31:0];
      SEL_SYSHI: rdData[SEC_HI_W-1:0] = sysSecIn[SEC_W-1:32];
      SEL_SYSNS: rdData[NS_W-1:0] = sysNsIn;
      default:   rdData = '0;
    endcase
  end

  assign sysTimerEn    = cfgLow[0];
  assign extBusEn      = cfgLow[1];
  assign overwriteMode = cfgLow[3:2];
  assign autoRefreshEn = cfgLow[4];
  assign ppsSnapEn     = cfgLow[5];
  assign portEn        = portEnR;
  assign swSec         = swSecR;
  assign swNs          = swNsR;
  assign swOffSec      = swOffSecR;
  assign swOffNs       = swOffNsR;

  // R3, R4: pulses only follow a qualifying write
  p_snap_src_r3: assert property (@(posedge clk) disable iff (rst)
    snapPulse |-> $past(stb.snap && wrData[0]));
  p_load_time_src_r4: assert property (@(posedge clk) disable iff (rst)
    loadTimePulse |-> $past(stb.load && wrData[0]));
  p_load_off_src_r4: assert property (@(posedge clk) disable iff (rst)
    loadOffsetPulse |-> $past(stb.load && wrData[1]));
  // R3, R4: trigger addresses read 0
  p_trig_reads_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (sel == SEL_SNAP || sel == SEL_LOAD) |-> (rdData == 32'h0));
  // R11: write-only addresses read 0
  p_wo_reads_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (sel == SEL_OFFLO || sel == SEL_OFFHI || sel == SEL_OFFNS) |-> (rdData == 32'h0));
  // R9: irq rises only after an event or an enable write
  p_irq_rise_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(masterPpsEvt || extPpsEvt || stb.ien));

endmodule

// File: rtl/timer_csr.sv
module timer_csr
  import timer_csr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int SEC_W  = 48,
  parameter int NS_W   = 30,
  parameter int PORTS  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  input  logic              masterPpsEvt,
  input  logic              extPpsEvt,
  input  logic [SEC_W-1:0]  sysSecIn,
  input  logic [NS_W-1:0]   sysNsIn,
  output logic              sysTimerEn,
  output logic              extBusEn,
  output logic [1:0]        overwriteMode,
  output logic              autoRefreshEn,
  output logic              ppsSnapEn,
  output logic [PORTS-1:0]  portEn,
  output logic              snapPulse,
  output logic              loadTimePulse,
  output logic              loadOffsetPulse,
  output logic [SEC_W-1:0]  swSec,
  output logic [NS_W-1:0]   swNs,
  output logic [SEC_W-1:0]  swOffSec,
  output logic [NS_W-1:0]   swOffNs,
  output logic              irq
);

  regSel_e    sel;
  wrStrobe_t  stb;

  timer_csr_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk  (clk),
    .rst  (rst),
    .addr (busAddr),
    .wrEn (busWrEn),
    .sel  (sel),
    .stb  (stb)
  );

  timer_csr_dp #(.SEC_W(SEC_W), .NS_W(NS_W), .PORTS(PORTS)) u_dp (
    .clk             (clk),
    .rst             (rst),
    .sel             (sel),
    .stb             (stb),
    .wrData          (busWrData),
    .masterPpsEvt    (masterPpsEvt),
    .extPpsEvt       (extPpsEvt),
    .sysSecIn        (sysSecIn),
    .sysNsIn         (sysNsIn),
    .rdData          (busRdData),
    .sysTimerEn      (sysTimerEn),
    .extBusEn        (extBusEn),
    .overwriteMode   (overwriteMode),
    .autoRefreshEn   (autoRefreshEn),
    .ppsSnapEn       (ppsSnapEn),
    .portEn          (portEn),
    .snapPulse       (snapPulse),
    .loadTimePulse   (loadTimePulse),
    .loadOffsetPulse (loadOffsetPulse),
    .swSec           (swSec),
    .swNs            (swNs),
    .swOffSec        (swOffSec),
    .swOffNs         (swOffNs),
    .irq             (irq)
  );

endmodule

// File: tb/tb_timer_csr.sv
module tb_timer_csr;

  localparam int ADDR_W = 12;
  localparam int SEC_W  = 48;
  localparam int NS_W   = 30;
  localparam int PORTS  = 4;
  localparam logic [31:0] CFG_MASK = 32'h000F_003F;
  localparam logic [31:0] IRQ_MASK = 32'h0001_0001;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [ADDR_W-1:0] busAddr = '0;
  logic busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic masterPpsEvt = 1'b0;
  logic extPpsEvt = 1'b0;
  logic [SEC_W-1:0] sysSecIn = 48'hA5C3_1234_9876;
  logic [NS_W-1:0] sysNsIn = 30'h2BCD_4321;
  logic sysTimerEn, extBusEn, autoRefreshEn, ppsSnapEn;
  logic [1:0] overwriteMode;
  logic [PORTS-1:0] portEn;
  logic snapPulse, loadTimePulse, loadOffsetPulse, irq;
  logic [SEC_W-1:0] swSec, swOffSec;
  logic [NS_W-1:0] swNs, swOffNs;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  bit done = 1'b0;

  // shadow model
  logic [31:0] mCfg = '0, mIen = '0, mSts = '0, mSecLo = '0, mSecHi = '0, mNs = '0;
  logic [31:0] mOffLo = '0, mOffHi = '0, mOffNs = '0;

  always #2 clk = ~clk;

  timer_csr #(.ADDR_W(ADDR_W), .SEC_W(SEC_W), .NS_W(NS_W), .PORTS(PORTS)) dut (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData),
    .masterPpsEvt(masterPpsEvt), .extPpsEvt(extPpsEvt),
    .sysSecIn(sysSecIn), .sysNsIn(sysNsIn),
    .sysTimerEn(sysTimerEn), .extBusEn(extBusEn), .overwriteMode(overwriteMode),
    .autoRefreshEn(autoRefreshEn), .ppsSnapEn(ppsSnapEn), .portEn(portEn),
    .snapPulse(snapPulse), .loadTimePulse(loadTimePulse),
    .loadOffsetPulse(loadOffsetPulse), .swSec(swSec), .swNs(swNs),
    .swOffSec(swOffSec), .swOffNs(swOffNs), .irq(irq)
  );

  function automatic logic [31:0] expRead(input logic [ADDR_W-1:0] a);
    case (32'(a))
      32'h000: return mCfg & CFG_MASK;
      32'h008: return mIen & IRQ_MASK;
      32'h00C: return mSts;
      32'h010: return mSecLo;
      32'h014: return mSecHi & 32'h0000_FFFF;
      32'h018: return mNs & 32'h3FFF_FFFF;
      32'h100: return sysSecIn[31:0];
      32'h104: return {16'h0, sysSecIn[47:32]};
      32'h108: return {2'b0, sysNsIn};
      default: return 32'h0;
    endcase
  endfunction

  function automatic bit isTouched(input int a);
    return a == 'h000 || a == 'h004 || a == 'h008 || a == 'h00C || a == 'h010 ||
           a == 'h014 || a == 'h018 || a == 'h01C || a == 'h028 || a == 'h02C ||
           a == 'h030;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rdChk(input string req, input logic [ADDR_W-1:0] a);
    busAddr = a;
    #1;
    chk(req, 64'(busRdData), 64'(expRead(a)));
  endtask

  task automatic chkOutputs(input string req);
    chk({req, " cfg outs"}, 64'({ppsSnapEn, autoRefreshEn, overwriteMode, extBusEn, sysTimerEn}),
        64'(mCfg[5:0]));
    chk({req, " portEn"}, 64'(portEn), 64'(mCfg[19:16]));
    chk({req, " swSec"}, 64'(swSec), {16'h0, mSecHi[15:0], mSecLo});
    chk({req, " swNs"}, 64'(swNs), 64'(mNs[29:0]));
    chk({req, " swOffSec"}, 64'(swOffSec), {16'h0, mOffHi[15:0], mOffLo});
    chk({req, " swOffNs"}, 64'(swOffNs), 64'(mOffNs[29:0]));
  endtask

  task automatic evt(input logic m, input logic e);
    @(negedge clk);
    masterPpsEvt = m; extPpsEvt = e;
    @(negedge clk);
    masterPpsEvt = 1'b0; extPpsEvt = 1'b0;
    mSts = mSts | {15'h0, e, 15'h0, m};
  endtask

  task automatic clearAll();
    wr(12'h00C, IRQ_MASK);
    mSts = '0;
  endtask

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      miscompares++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    chkOutputs("R1");
    chk("R1 pulses", 64'({snapPulse, loadTimePulse, loadOffsetPulse}), 64'h0);
    chk("R1 irq", 64'(irq), 64'h0);
    for (int a = 0; a < 'h110; a += 4) rdChk("R1 read", ADDR_W'(a));

    // R2: walking ones over the configuration word
    for (int i = 0; i < 32; i++) begin
      wr(12'h000, 32'h1 << i);
      mCfg = 32'h1 << i;
      rdChk("R2 cfg read", 12'h000);
      chkOutputs("R2");
    end
    wr(12'h000, 32'hFFFF_FFFF); mCfg = 32'hFFFF_FFFF;
    rdChk("R2 cfg all", 12'h000);
    chkOutputs("R2 all");

    // R3: snapshot trigger
    wr(12'h004, 32'h1);
    chk("R3 snap high", 64'(snapPulse), 64'h1);
    @(negedge clk);
    chk("R3 snap one cycle", 64'(snapPulse), 64'h0);
    wr(12'h004, 32'hFFFF_FFFE);
    chk("R3 snap zero write", 64'(snapPulse), 64'h0);
    rdChk("R3 snap reads 0", 12'h004);

    // R4: load triggers, all bit-0/bit-1 combinations
    for (int v = 0; v < 4; v++) begin
      wr(12'h01C, 32'(v));
      chk("R4 load pulses", 64'({loadOffsetPulse, loadTimePulse}), 64'(v));
      chk("R4 no snap", 64'(snapPulse), 64'h0);
      @(negedge clk);
      chk("R4 pulses end", 64'({loadOffsetPulse, loadTimePulse}), 64'h0);
      rdChk("R4 load reads 0", 12'h01C);
    end

    // R10: software time
    for (int i = 0; i < 32; i++) begin
      wr(12'h010, 32'h1 << i); mSecLo = 32'h1 << i;
      rdChk("R10 secLo", 12'h010);
    end
    wr(12'h014, 32'hFFFF_FFFF); mSecHi = 32'hFFFF_FFFF;
    wr(12'h018, 32'hFFFF_FFFF); mNs = 32'hFFFF_FFFF;
    rdChk("R10 secHi", 12'h014);
    rdChk("R10 ns", 12'h018);
    chkOutputs("R10");
    wr(12'h018, 32'h1234_5678); mNs = 32'h1234_5678;
    rdChk("R10 ns pattern", 12'h018);
    chkOutputs("R10 pattern");

    // R11: write-only offset
    wr(12'h028, 32'hDEAD_BEEF); mOffLo = 32'hDEAD_BEEF;
    wr(12'h02C, 32'hFFFF_5A5A); mOffHi = 32'hFFFF_5A5A;
    wr(12'h030, 32'hFFFF_FFFF); mOffNs = 32'hFFFF_FFFF;
    chkOutputs("R11");
    rdChk("R11 offLo reads 0", 12'h028);
    rdChk("R11 offHi reads 0", 12'h02C);
    rdChk("R11 offNs reads 0", 12'h030);

    // R5: enable register
    wr(12'h008, 32'hFFFF_FFFF); mIen = 32'hFFFF_FFFF;
    rdChk("R5 ien", 12'h008);
    wr(12'h008, 32'h0); mIen = 32'h0;
    rdChk("R5 ien clear", 12'h008);

    // R6: events set status with enable clear, and stay set
    evt(1'b1, 1'b0);
    rdChk("R6 master sets", 12'h00C);
    evt(1'b0, 1'b1);
    rdChk("R6 ext sets", 12'h00C);
    repeat (5) @(negedge clk);
    rdChk("R6 sticky", 12'h00C);
    chk("R6 irq masked", 64'(irq), 64'h0);

    // R7: write-one-to-clear, bit by bit
    wr(12'h00C, 32'hFFFE_FFFE);
    rdChk("R7 zeros keep", 12'h00C);
    wr(12'h00C, 32'h0000_0001); mSts = 32'h0001_0000;
    rdChk("R7 clear bit0", 12'h00C);
    wr(12'h00C, 32'h0001_0000); mSts = 32'h0;
    rdChk("R7 clear bit16", 12'h00C);
    chkOutputs("R7 others unchanged");

    // R8: clear and event in the same cycle, every combination
    for (int c = 0; c < 4; c++) begin
      for (int e = 0; e < 4; e++) begin
        clearAll();
        evt(1'b1, 1'b1);
        @(negedge clk);
        busAddr = 12'h00C;
        busWrData = {15'h0, c[1], 15'h0, c[0]};
        busWrEn = 1'b1;
        masterPpsEvt = e[0]; extPpsEvt = e[1];
        @(negedge clk);
        busWrEn = 1'b0; masterPpsEvt = 1'b0; extPpsEvt = 1'b0;
        mSts = {15'h0, !c[1] || e[1], 15'h0, !c[0] || e[0]};
        rdChk("R8 event wins", 12'h00C);
      end
    end

    // R9: irq over all enable/status combinations
    for (int en = 0; en < 4; en++) begin
      for (int st = 0; st < 4; st++) begin
        clearAll();
        wr(12'h008, {15'h0, en[1], 15'h0, en[0]});
        mIen = {15'h0, en[1], 15'h0, en[0]};
        if (st != 0) evt(st[0], st[1]);
        #1;
        chk("R9 irq", 64'(irq), 64'((en[0] & st[0]) | (en[1] & st[1])));
      end
    end

    // R12: read-only time, writes ignored
    rdChk("R12 sysLo", 12'h100);
    rdChk("R12 sysHi", 12'h104);
    rdChk("R12 sysNs", 12'h108);
    sysSecIn = 48'h0F0F_1357_2468; sysNsIn = 30'h0ACE_BDF0;
    @(negedge clk);
    rdChk("R12 sysLo live", 12'h100);
    rdChk("R12 sysHi live", 12'h104);
    rdChk("R12 sysNs live", 12'h108);

    // R13 and R12: all-ones writes to every untouched word and some unaligned bytes
    for (int a = 0; a < (1 << ADDR_W); a += 4) begin
      if (!isTouched(a)) wr(ADDR_W'(a), 32'hFFFF_FFFF);
    end
    for (int a = 1; a < 'h40; a += 3) begin
      if (a % 4 != 0) wr(ADDR_W'(a), 32'hFFFF_FFFF);
    end
    chkOutputs("R13 writes ignored");
    chk("R13 no pulses", 64'({snapPulse, loadTimePulse, loadOffsetPulse}), 64'h0);
    for (int a = 0; a < (1 << ADDR_W); a += 4) rdChk("R13 map sweep", ADDR_W'(a));
    for (int a = 1; a < 'h40; a += 3) rdChk("R13 unaligned", ADDR_W'(a));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule